// File: doc/BRIEF.md
# Stress-Recovery Waveform Sequencer

The sequencer drives three 16-bit output channels, meant for three DACs, through one stress phase and then one recovery phase of a transistor reliability experiment. Software picks one of four stress modes and supplies, for each channel, a stress code, an alternate code and a recovery code. It also supplies phase durations counted in ticks of an external 500 ns timebase. A start pulse closes the relay that connects the device terminals. After a fixed settle delay the stress waveform begins. Every stress run ends with all three channels at their recovery codes, and the relay opens again when the recovery window has run out.

Each time the channel values change, all three change together in the same cycle, together with a one-cycle update strobe that the DAC side latches on. A level flag marks the recovery phase. A one-cycle recovery-start pulse coincides with the strobe that applies the recovery codes, so the acquisition side can align its time origin with it. An abort input forces the recovery codes at once and then opens the relay.

Top module: `stress_seq`

## Requirements
- R1: After reset all three channel outputs are 0, and the update strobe, connect enable, recovery flag and recovery-start pulse are all low.
- R2: A start pulse seen while idle raises the connect enable on the next cycle. No update strobe is issued while the connect enable is low, nor in the cycle it rises. The first stress update follows exactly SETTLE_TICKS ticks later.
- R3: Mode 0 (constant stress) applies the stress codes for dur_stress ticks and then applies the recovery codes.
- R4: Mode 1 (square wave) alternates the stress codes for dur_hi ticks and the alternate codes for dur_lo ticks, for ac_cycles full periods, and then applies the recovery codes.
- R5: Mode 2 (stress plus pulse) applies the stress codes for dur_stress ticks, then the alternate codes for dur_pulse ticks, then the recovery codes.
- R6: Mode 3 (stress plus square wave) applies the stress codes for dur_stress ticks, then runs the mode 1 square wave, then applies the recovery codes.
- R7: Every value change updates all three channels in the same cycle, together with a one-cycle update strobe. Channel k takes bits 16k+15 down to 16k of each code bus, with channel 0 on dac_a, channel 1 on dac_b and channel 2 on dac_c.
- R8: The recovery flag is high for exactly the recovery phase. The recovery-start pulse is high for one cycle, together with the strobe that applies the recovery codes. The connect enable falls dur_recov ticks after that strobe.
- R9: A duration or cycle count of 0 is treated as 1. Each half period therefore lasts at least one 500 ns tick, which keeps the output toggle rate at or below 1 MHz.
- R10: An abort while the relay is closed produces, on the next cycle, a strobe that applies the recovery codes, with no recovery-start pulse. The connect enable falls one cycle after that strobe. An abort while idle has no effect.
- R11: A start pulse while a run is in progress is ignored. The mode is captured when the run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse, every 500 ns |
| start | input | 1 | Begin a run (used only while idle) |
| abort | input | 1 | Force recovery codes, then disconnect |
| mode | input | 2 | 0 constant, 1 square wave, 2 stress plus pulse, 3 stress plus square wave |
| code_stress | input | 48 | Stress codes, 16 bits per channel |
| code_alt | input | 48 | Square-wave low or pulse codes |
| code_recov | input | 48 | Recovery bias codes |
| dur_stress | input | 32 | Constant-stress length in ticks |
| dur_hi | input | 32 | Square-wave high half in ticks |
| dur_lo | input | 32 | Square-wave low half in ticks |
| dur_pulse | input | 32 | Pulse length in ticks |
| dur_recov | input | 32 | Recovery window in ticks |
| ac_cycles | input | 32 | Number of square-wave periods |
| dac_a | output | 16 | Channel 0 code |
| dac_b | output | 16 | Channel 1 code |
| dac_c | output | 16 | Channel 2 code |
| dac_upd | output | 1 | Synchronous update strobe |
| term_connect | output | 1 | Relay enable for the device terminals |
| recov_phase | output | 1 | High during the recovery phase |
| recov_start | output | 1 | One-cycle marker of the recovery update |

## Verification
A wrong phase register shows up at the next strobe: the codes applied are wrong, or the number of strobes in the run is wrong. A wrong tick counter shows up as a tick count between consecutive strobes that differs from the programmed duration. That difference is visible at the strobe that ends the affected phase. A fault in the relay logic shows up as a settle count, or a disconnect delay, that is off by ticks or cycles. A fault in the abort path shows up within two cycles, as a missing recovery strobe or a relay that stays closed.

// File: rtl/stress_seq.sv
module stress_seq #(
  parameter int DW = 16,
  parameter int TW = 32,
  parameter int SETTLE_TICKS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            start,
  input  logic            abort,
  input  logic [1:0]      mode,
  input  logic [3*DW-1:0] code_stress,
  input  logic [3*DW-1:0] code_alt,
  input  logic [3*DW-1:0] code_recov,
  input  logic [TW-1:0]   dur_stress,
  input  logic [TW-1:0]   dur_hi,
  input  logic [TW-1:0]   dur_lo,
  input  logic [TW-1:0]   dur_pulse,
  input  logic [TW-1:0]   dur_recov,
  input  logic [TW-1:0]   ac_cycles,
  output logic [DW-1:0]   dac_a,
  output logic [DW-1:0]   dac_b,
  output logic [DW-1:0]   dac_c,
  output logic            dac_upd,
  output logic            term_connect,
  output logic            recov_phase,
  output logic            recov_start
);
  localparam logic [TW-1:0] SET_LAST = (SETTLE_TICKS > 1) ? TW'(SETTLE_TICKS - 1) : '0;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_DC, S_HI, S_LO, S_PULSE, S_REC, S_DRAIN} st_t;

  st_t st, ns, after_dc;
  logic [TW-1:0] cnt, cyc, last;
  logic [1:0] mode_q;
  logic [3*DW-1:0] dac_q, nxt_code;
  logic load, done, upd_q, rs_q;

  function automatic logic [TW-1:0] lim(input logic [TW-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  always_comb begin
    case (st)
      S_SETTLE: last = SET_LAST;
      S_DC:     last = lim(dur_stress);
      S_HI:     last = lim(dur_hi);
      S_LO:     last = lim(dur_lo);
      S_PULSE:  last = lim(dur_pulse);
      S_REC:    last = lim(dur_recov);
      default:  last = '0;
    endcase
  end

  assign done = tick && (cnt == last);
  assign after_dc = (mode_q == 2'd0) ? S_REC : (mode_q == 2'd2) ? S_PULSE : S_HI;

  always_comb begin
    ns = st;
    case (st)
      S_IDLE:   if (start) ns = S_SETTLE;
      S_SETTLE: if (done) ns = (mode_q == 2'd1) ? S_HI : S_DC;
      S_DC:     if (done) ns = after_dc;
      S_HI:     if (done) ns = S_LO;
      S_LO:     if (done) ns = (cyc == lim(ac_cycles)) ? S_REC : S_HI;
      S_PULSE:  if (done) ns = S_REC;
      S_REC:    if (done) ns = S_IDLE;
      default:  ns = S_IDLE;
    endcase
    if (abort && st != S_IDLE && st != S_DRAIN) ns = S_DRAIN;
  end

  assign load = (ns != st) && (ns != S_IDLE) && (ns != S_SETTLE);

  always_comb begin
    case (ns)
      S_DC, S_HI:    nxt_code = code_stress;
      S_LO, S_PULSE: nxt_code = code_alt;
      default:       nxt_code = code_recov;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      cyc <= '0;
      mode_q <= '0;
      dac_q <= '0;
      upd_q <= 1'b0;
      rs_q <= 1'b0;
    end else begin
      st <= ns;
      cnt <= (ns != st) ? '0 : (tick ? cnt + 1'b1 : cnt);
      if (st == S_IDLE) cyc <= '0;
      else if (st == S_LO && ns == S_HI) cyc <= cyc + 1'b1;
      if (st == S_IDLE && start) mode_q <= mode;
      if (load) dac_q <= nxt_code;
      upd_q <= load;
      rs_q <= load && (ns == S_REC);
    end
  end

  assign dac_a = dac_q[DW-1:0];
  assign dac_b = dac_q[2*DW-1:DW];
  assign dac_c = dac_q[3*DW-1:2*DW];
  assign dac_upd = upd_q;
  assign recov_start = rs_q;
  assign term_connect = (st != S_IDLE);
  assign recov_phase = (st == S_REC);

  AST_UPD_CONNECTED: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd |-> term_connect); // R2
  AST_NO_EARLY_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_connect) |-> !dac_upd); // R2
  AST_RS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    recov_start |-> (dac_upd && recov_phase)); // R8
  AST_REC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recov_phase) |-> recov_start); // R8
  AST_ABORT_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && term_connect && !dac_upd) |=> (dac_upd && !recov_start && {dac_c, dac_b, dac_a} == $past(code_recov))); // R10
endmodule

// File: tb/stress_seq_tb.sv
module stress_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int SET = 4;
  localparam int NROW = 6;
  localparam int ROWS [NROW][7] = '{
    '{0, 3, 0, 0, 0, 0, 2},
    '{1, 0, 2, 3, 2, 0, 3},
    '{2, 4, 0, 0, 0, 2, 1},
    '{3, 2, 1, 2, 3, 0, 2},
    '{1, 0, 0, 0, 0, 0, 0},
    '{2, 0, 0, 0, 0, 0, 5}
  };

  logic clk = 0, rst_n = 0, tick = 0, start = 0, abort = 0;
  logic [1:0] mode = 0;
  logic [47:0] code_stress = 0, code_alt = 0, code_recov = 0;
  logic [31:0] dur_stress = 0, dur_hi = 0, dur_lo = 0, dur_pulse = 0, dur_recov = 0, ac_cycles = 0;
  logic [15:0] dac_a, dac_b, dac_c;
  logic dac_upd, term_connect, recov_phase, recov_start;

  stress_seq #(.DW(16), .TW(32), .SETTLE_TICKS(SET)) dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int n_ev = 0, tk = 0, tdiv = 0, cyc_n = 0, rise_tk = 0, fall_tk = 0, fall_cy = 0, stray_rs = 0;
  bit done_f = 0, prev_c = 0;
  logic [47:0] ev_val [64];
  int ev_tk [64], ev_cy [64];
  bit ev_rs [64], ev_rec [64];

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_n++;
    if (cyc_n > 100000) begin
      chk("watchdog", 0, cyc_n, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (dac_upd && n_ev < 64) begin
      ev_val[n_ev] = {dac_c, dac_b, dac_a};
      ev_tk[n_ev] = tk; ev_cy[n_ev] = cyc_n;
      ev_rs[n_ev] = recov_start; ev_rec[n_ev] = recov_phase;
      n_ev++;
    end
    if (!dac_upd && recov_start) stray_rs++;
    if (term_connect && !prev_c) rise_tk = tk;
    if (!term_connect && prev_c) begin fall_tk = tk; fall_cy = cyc_n; done_f = 1; end
    prev_c = term_connect;
    if (tdiv == 2) begin tick = 1; tdiv = 0; tk++; end
    else begin tick = 0; tdiv++; end
  end

  function automatic logic [47:0] mk(input logic [15:0] base, input int i);
    return {base + 16'h0200 + 16'(i), base + 16'h0100 + 16'(i), base + 16'(i)};
  endfunction

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic go();
    @(negedge clk);
    n_ev = 0; done_f = 0; stray_rs = 0;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_row(input int r, input bit poke);
    logic [47:0] xv [64];
    int xd [64];
    int np = 0;
    string tag;
    mode = 2'(ROWS[r][0]);
    dur_stress = ROWS[r][1]; dur_hi = ROWS[r][2]; dur_lo = ROWS[r][3];
    ac_cycles = ROWS[r][4]; dur_pulse = ROWS[r][5]; dur_recov = ROWS[r][6];
    code_stress = mk(16'h1000, r); code_alt = mk(16'h5000, r); code_recov = mk(16'h8000, r);
    case (ROWS[r][0])
      0: tag = "R3";
      1: tag = "R4";
      2: tag = "R5";
      default: tag = "R6";
    endcase
    if (r >= 4) tag = "R9";
    if (poke) tag = "R11";
    if (ROWS[r][0] != 1) begin xv[np] = code_stress; xd[np] = eff(ROWS[r][1]); np++; end
    if (ROWS[r][0] == 2) begin xv[np] = code_alt; xd[np] = eff(ROWS[r][5]); np++; end
    if (ROWS[r][0] == 1 || ROWS[r][0] == 3)
      for (int c = 0; c < eff(ROWS[r][4]); c++) begin
        xv[np] = code_stress; xd[np] = eff(ROWS[r][2]); np++;
        xv[np] = code_alt; xd[np] = eff(ROWS[r][3]); np++;
      end
    xv[np] = code_recov; xd[np] = eff(ROWS[r][6]); np++;
    go();
    if (poke) begin
      while (n_ev < 1) @(negedge clk);
      mode = ~mode;
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done_f) @(negedge clk);
    chk({tag, " update count"}, n_ev == np, n_ev, np);
    chk("R2 settle ticks", ev_tk[0] - rise_tk == SET, ev_tk[0] - rise_tk, SET);
    for (int k = 0; k < np && k < n_ev; k++) begin
      chk({tag, " R7 codes"}, ev_val[k] == xv[k], ev_val[k], xv[k]);
      if (k > 0) chk({tag, " phase ticks"}, ev_tk[k] - ev_tk[k-1] == xd[k-1], ev_tk[k] - ev_tk[k-1], xd[k-1]);
      chk("R8 recovery flags", {ev_rs[k], ev_rec[k]} == {2{k == np - 1}}, {ev_rs[k], ev_rec[k]}, {2{k == np - 1}});
    end
    if (n_ev >= 1)
      chk("R8 disconnect ticks", fall_tk - ev_tk[n_ev-1] == xd[np-1], fall_tk - ev_tk[n_ev-1], xd[np-1]);
    chk("R8 stray start pulse", stray_rs == 0, stray_rs, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {dac_c, dac_b, dac_a} == 0 && !dac_upd && !term_connect && !recov_phase && !recov_start,
        {dac_c, dac_b, dac_a}, 0);
    for (int r = 0; r < NROW; r++) run_row(r, 0);
    run_row(2, 1);
    mode = 0; dur_stress = 40; dur_recov = 3;
    code_stress = mk(16'h2000, 9); code_recov = mk(16'h9000, 9);
    go();
    while (n_ev < 1) @(negedge clk);
    repeat (5) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    while (!done_f) @(negedge clk);
    chk("R10 abort update count", n_ev == 2, n_ev, 2);
    chk("R10 abort codes", ev_val[1] == code_recov, ev_val[1], code_recov);
    chk("R10 no recovery pulse", ev_rs[1] == 0, ev_rs[1], 0);
    chk("R10 disconnect cycle", fall_cy - ev_cy[1] == 1, fall_cy - ev_cy[1], 1);
    n_ev = 0;
    abort = 1;
    @(negedge clk);
    abort = 0;
    repeat (10) @(negedge clk);
    chk("R10 idle abort ignored", n_ev == 0 && !term_connect, n_ev, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule